// File: doc/BRIEF.md
# Page-Aligned Write Chunker

This block takes one byte-write request, given as a start offset into flash and a byte count, and cuts it into program chunks. No chunk crosses a 256-byte page boundary. Each chunk carries three values: the flash address where it starts, its length, and the index into the caller's source buffer where its data begins. The chunks go out one at a time to a flash command sequencer, which turns each one into a single page-program command.

At acceptance the block compares the page holding the first byte with the page holding the offset plus the count. If the two are the same page, the request leaves as one chunk. Otherwise it leaves in up to three parts:
- a head chunk running from the offset to the end of its page,
- zero or more full pages,
- a tail chunk with whatever bytes remain.

A request with a non-zero count raises a write-pending flag. That flag tells the sequencer to poll the busy status before its next operation. The flag stays up until the sequencer clears it.

The request input and the chunk output both use a valid/ready handshake, with these back-pressure rules:
- The block takes a request only while it is idle.
- Once a chunk is offered, its address, length, index and last flag stay unchanged until the sequencer takes it.
- The sequencer may hold `chunk_ready` low for any number of cycles.

`done` and the pending flag are plain level pins.

Top module: `page_chunker`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `req_ready` is 1 and `chunk_valid`, `done` and `wr_pending` are 0.
- R2: If `offset>>8` equals `(offset+count)>>8` (25-bit sum) and the count is non-zero, exactly one chunk is emitted: address = offset, length = count, buffer index = 0, `chunk_last` = 1.
- R3: Otherwise the first chunk has address = offset, buffer index = 0 and length = 256 − (offset mod 256).
- R4: After the first chunk, each chunk's address and buffer index exceed the previous chunk's by the previous chunk's length. While 256 or more bytes remain, the chunk length is 256.
- R5: When fewer than 256 but more than zero bytes remain, one final chunk carries all of them. No chunk of length zero is ever emitted, so a request ending exactly on a page boundary ends with its last full chunk.
- R6: `chunk_last` is 1 on the final chunk of a request and 0 on every other chunk.
- R7: While `chunk_valid` is 1 and `chunk_ready` is 0, `chunk_valid`, address, length, index and last hold in the next cycle. `req_ready` is 0 from acceptance of a non-zero request until its final chunk is taken.
- R8: A request with count 0 emits no chunk. `done` is 1 in the cycle after that request is accepted.
- R9: `done` is a one-cycle pulse in the cycle after the final chunk's handshake. `req_ready` is 1 again in that same cycle.
- R10: `wr_pending` becomes 1 in the cycle after a non-zero request is accepted. It stays 1 until a cycle with `pend_clr` = 1, after which it reads 0. If a set and `pend_clr` fall in the same cycle, the set wins. A zero-count request does not set the flag.
- R11: Every emitted chunk satisfies (address mod 256) + length ≤ 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_offset | input | 24 | Flash byte offset of the first byte |
| req_count | input | 16 | Number of bytes to write |
| chunk_valid | output | 1 | Chunk offered |
| chunk_ready | input | 1 | Sequencer takes the chunk |
| chunk_addr | output | 24 | Flash address of the chunk |
| chunk_len | output | 9 | Chunk length in bytes, 1 to 256 |
| chunk_idx | output | 16 | Source buffer index of the chunk's first byte |
| chunk_last | output | 1 | Chunk is the final one of its request |
| done | output | 1 | One-cycle pulse when a request is finished |
| pend_clr | input | 1 | Sequencer finished its busy wait; clears the pending flag |
| wr_pending | output | 1 | A write was issued and the busy status must be polled first |

## Verification
The checker watches every cycle for the following:
- that outputs hold steady under back-pressure,
- that no chunk crosses a page or has length zero,
- that consecutive chunks continue each other's address,
- that a zero-count request leads to `done`,
- that an accepted request sets the pending flag,
- that the two handshakes never overlap.

Other behaviour depends on the whole request, so only the bench scenarios can show it. This covers:
- the choice between the single-chunk path and the split path at page-boundary offsets,
- the exact head, middle and tail lengths,
- the chunk count per request,
- where `chunk_last` falls,
- the clearing of the pending flag and its set-over-clear priority.

// File: rtl/pgsplit_pkg.sv
package pgsplit_pkg;
  typedef enum logic {
    ST_IDLE,
    ST_EMIT
  } split_st_e;
endpackage

// File: rtl/pgsplit_pagecmp.sv
// Decides at acceptance whether a request stays inside one page.
module pgsplit_pagecmp #(
  parameter int ADDR_W    = 24,
  parameter int CNT_W     = 16,
  parameter int PAGE_BITS = 8
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic [CNT_W-1:0]  count,
  output logic              one_page
);
  localparam int SUM_W = ADDR_W + 1;

  logic [SUM_W-1:0] end_sum;
  logic [SUM_W-PAGE_BITS-1:0] start_pg;
  logic [SUM_W-PAGE_BITS-1:0] end_pg;

  always_comb begin
    end_sum  = {1'b0, offset} + SUM_W'(count);
    start_pg = {1'b0, offset[ADDR_W-1:PAGE_BITS]};
    end_pg   = end_sum[SUM_W-1:PAGE_BITS];
    one_page = (start_pg == end_pg);
  end
endmodule

// File: rtl/pgsplit_len.sv
// Length of the chunk at the current position.
module pgsplit_len #(
  parameter int CNT_W     = 16,
  parameter int PAGE_BITS = 8
) (
  input  logic [PAGE_BITS-1:0] addr_lo,
  input  logic [CNT_W-1:0]     remain,
  input  logic                 fast,
  output logic [PAGE_BITS:0]   len,
  output logic                 last
);
  localparam int LEN_W = PAGE_BITS + 1;
  localparam logic [LEN_W-1:0] PAGE_SZ = LEN_W'(1) << PAGE_BITS;

  logic [LEN_W-1:0] room;
  logic             fits;

  always_comb begin
    room = PAGE_SZ - {1'b0, addr_lo};
    fits = (remain <= CNT_W'(room));
    if (fast || fits) begin
      len  = remain[LEN_W-1:0];
      last = 1'b1;
    end else begin
      len  = room;
      last = 1'b0;
    end
  end
endmodule

// File: rtl/pgsplit_pend.sv
// Write-pending flag: set wins over clear.
module pgsplit_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/page_chunker.sv
module page_chunker
  import pgsplit_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int CNT_W     = 16,
  parameter int PAGE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_offset,
  input  logic [CNT_W-1:0]     req_count,
  output logic                 chunk_valid,
  input  logic                 chunk_ready,
  output logic [ADDR_W-1:0]    chunk_addr,
  output logic [PAGE_BITS:0]   chunk_len,
  output logic [CNT_W-1:0]     chunk_idx,
  output logic                 chunk_last,
  output logic                 done,
  input  logic                 pend_clr,
  output logic                 wr_pending
);
  localparam int LEN_W = PAGE_BITS + 1;

  split_st_e         st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q;
  logic [CNT_W-1:0]  idx_q;
  logic              fast_q;
  logic              done_q;
  logic              one_page;
  logic              take_req;
  logic              take_chunk;
  logic [LEN_W-1:0]  len_w;
  logic              last_w;

  pgsplit_pagecmp #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_BITS(PAGE_BITS)
  ) u_cmp (
    .offset  (req_offset),
    .count   (req_count),
    .one_page(one_page)
  );

  pgsplit_len #(
    .CNT_W(CNT_W), .PAGE_BITS(PAGE_BITS)
  ) u_len (
    .addr_lo(addr_q[PAGE_BITS-1:0]),
    .remain (rem_q),
    .fast   (fast_q),
    .len    (len_w),
    .last   (last_w)
  );

  assign req_ready   = (st_q == ST_IDLE);
  assign chunk_valid = (st_q == ST_EMIT);
  assign take_req    = req_valid && req_ready;
  assign take_chunk  = chunk_valid && chunk_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      idx_q  <= '0;
      fast_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take_req) begin
        if (req_count == '0) begin
          done_q <= 1'b1;
        end else begin
          st_q   <= ST_EMIT;
          addr_q <= req_offset;
          rem_q  <= req_count;
          idx_q  <= '0;
          fast_q <= one_page;
        end
      end else if (take_chunk) begin
        if (last_w) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end else begin
          addr_q <= addr_q + ADDR_W'(len_w);
          rem_q  <= rem_q - CNT_W'(len_w);
          idx_q  <= idx_q + CNT_W'(len_w);
          fast_q <= 1'b0;
        end
      end
    end
  end

  pgsplit_pend u_pend (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (take_req && (req_count != '0)),
    .clr  (pend_clr),
    .q    (wr_pending)
  );

  assign chunk_addr = addr_q;
  assign chunk_len  = len_w;
  assign chunk_idx  = idx_q;
  assign chunk_last = last_w;
  assign done       = done_q;
endmodule

// File: rtl/page_chunker_chk.sv
module page_chunker_chk #(
  parameter int ADDR_W    = 24,
  parameter int CNT_W     = 16,
  parameter int PAGE_BITS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [CNT_W-1:0]   req_count,
  input logic               chunk_valid,
  input logic               chunk_ready,
  input logic [ADDR_W-1:0]  chunk_addr,
  input logic [PAGE_BITS:0] chunk_len,
  input logic [CNT_W-1:0]   chunk_idx,
  input logic               chunk_last,
  input logic               done,
  input logic               wr_pending
);
  // R7
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_valid && !chunk_ready) |=> (chunk_valid && $stable(chunk_addr) &&
      $stable(chunk_len) && $stable(chunk_idx) && $stable(chunk_last)));

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && chunk_valid));

  // R11
  page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid |-> (int'(chunk_addr[PAGE_BITS-1:0]) + int'(chunk_len) <= (1 << PAGE_BITS)));

  // R5
  nonzero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid |-> (chunk_len != '0));

  // R4
  addr_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_valid && chunk_ready && !chunk_last) |=>
      (chunk_valid && (chunk_addr == $past(chunk_addr) + ADDR_W'($past(chunk_len)))));

  // R8
  zero_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_count == '0) |=> (done && !chunk_valid));

  // R9
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_valid && chunk_ready && chunk_last) |=> (done && req_ready));

  // R10
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_count != '0) |=> wr_pending);
endmodule

bind page_chunker page_chunker_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_count  (req_count),
  .chunk_valid(chunk_valid),
  .chunk_ready(chunk_ready),
  .chunk_addr (chunk_addr),
  .chunk_len  (chunk_len),
  .chunk_idx  (chunk_idx),
  .chunk_last (chunk_last),
  .done       (done),
  .wr_pending (wr_pending)
);

// File: tb/sim_page_chunker.sv
module sim_page_chunker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [23:0] req_offset;
  logic [15:0] req_count;
  logic        chunk_valid;
  logic        chunk_ready;
  logic [23:0] chunk_addr;
  logic [8:0]  chunk_len;
  logic [15:0] chunk_idx;
  logic        chunk_last;
  logic        done;
  logic        pend_clr;
  logic        wr_pending;

  always #4 clk = ~clk;

  page_chunker u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_offset(req_offset), .req_count(req_count),
    .chunk_valid(chunk_valid), .chunk_ready(chunk_ready),
    .chunk_addr(chunk_addr), .chunk_len(chunk_len),
    .chunk_idx(chunk_idx), .chunk_last(chunk_last),
    .done(done), .pend_clr(pend_clr), .wr_pending(wr_pending)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  localparam int NV = 10;
  localparam logic [23:0] V_OFF [NV] = '{24'h000010, 24'h0000F0, 24'h000000, 24'h000080,
    24'h001234, 24'h0000FF, 24'h000100, 24'hFFFF00, 24'h000001, 24'h000005};
  localparam logic [15:0] V_CNT [NV] = '{16'd16, 16'd16, 16'd256, 16'd768,
    16'd1, 16'd2, 16'd1024, 16'd256, 16'd255, 16'd1000};
  localparam int V_NCH [NV] = '{1, 1, 1, 4, 1, 2, 4, 1, 1, 4};

  task automatic run_req(input logic [23:0] off, input logic [15:0] cnt,
                         input int nch, input int pat);
    logic [24:0] endsum;
    logic [23:0] eaddr;
    int          erem;
    int          eidx;
    int          elen;
    bit          first;
    int          got;
    bit          stalled;
    logic [23:0] s_addr;
    logic [8:0]  s_len;
    logic [15:0] s_idx;
    logic        s_last;
    @(negedge clk);
    chk("R9 req_ready idle", 32'(req_ready), 32'd1);
    req_valid  = 1'b1;
    req_offset = off;
    req_count  = cnt;
    @(posedge clk);
    #1 req_valid = 1'b0;
    endsum  = {1'b0, off} + 25'(cnt);
    eaddr   = off;
    erem    = int'(cnt);
    eidx    = 0;
    first   = 1'b1;
    got     = 0;
    stalled = 1'b0;
    for (int cyc = 0; cyc < 5000; cyc++) begin
      @(negedge clk);
      if (stalled) begin
        chk("R7 stall valid", 32'(chunk_valid), 32'd1);
        chk("R7 stall addr", 32'(chunk_addr), 32'(s_addr));
        chk("R7 stall len", 32'(chunk_len), 32'(s_len));
        chk("R7 stall idx", 32'(chunk_idx), 32'(s_idx));
        chk("R7 stall last", 32'(chunk_last), 32'(s_last));
        stalled = 1'b0;
      end
      chk("R7 busy req_ready", 32'(req_ready), 32'd0);
      chunk_ready = ((cyc + pat) % 3) != 0;
      #1;
      if (chunk_valid && chunk_ready) begin
        if (first) begin
          if ({1'b0, off[23:8]} == endsum[24:8]) elen = int'(cnt);
          else elen = 256 - int'(off[7:0]);
        end else begin
          elen = (erem >= 256) ? 256 : erem;
        end
        chk(first ? "R2/R3 first addr" : "R4 addr", 32'(chunk_addr), 32'(eaddr));
        chk(first ? "R2/R3 first len" : "R4/R5 len", 32'(chunk_len), 32'(elen));
        chk("R4 idx", 32'(chunk_idx), 32'(eidx));
        chk("R6 last", 32'(chunk_last), 32'(erem == elen));
        chk("R11 page cross", 32'(int'(chunk_addr[7:0]) + int'(chunk_len) <= 256), 32'd1);
        got++;
        eaddr = eaddr + 24'(elen);
        erem  = erem - elen;
        eidx  = eidx + elen;
        first = 1'b0;
        if (chunk_last) begin
          @(negedge clk);
          chunk_ready = 1'b0;
          chk("R9 done pulse", 32'(done), 32'd1);
          chk("R9 req_ready back", 32'(req_ready), 32'd1);
          @(negedge clk);
          chk("R9 done one cycle", 32'(done), 32'd0);
          break;
        end
      end else if (chunk_valid) begin
        stalled = 1'b1;
        s_addr = chunk_addr;
        s_len  = chunk_len;
        s_idx  = chunk_idx;
        s_last = chunk_last;
      end
    end
    chk("R5 chunk count", 32'(got), 32'(nch));
    chk("R5 bytes left", 32'(erem), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R9 watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_offset = '0;
    req_count = '0;
    chunk_ready = 1'b0;
    pend_clr = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 req_ready", 32'(req_ready), 32'd1);
    chk("R1 chunk_valid", 32'(chunk_valid), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 wr_pending", 32'(wr_pending), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 32'({req_ready, chunk_valid, done, wr_pending}), 32'b1000);

    for (int v = 0; v < NV; v++) begin
      run_req(V_OFF[v], V_CNT[v], V_NCH[v], v);
    end

    // R10: pending set, held, then cleared
    chk("R10 pending held", 32'(wr_pending), 32'd1);
    pend_clr = 1'b1;
    @(negedge clk);
    pend_clr = 1'b0;
    chk("R10 pending cleared", 32'(wr_pending), 32'd0);

    // R8: zero count
    req_valid = 1'b1;
    req_offset = 24'h000040;
    req_count = 16'd0;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    chk("R8 done after zero", 32'(done), 32'd1);
    chk("R8 no chunk", 32'(chunk_valid), 32'd0);
    chk("R10 zero leaves pending", 32'(wr_pending), 32'd0);
    @(negedge clk);
    chk("R8 still no chunk", 32'(chunk_valid), 32'd0);
    chk("R8 done one cycle", 32'(done), 32'd0);

    // R10: set beats clear in the same cycle
    req_valid = 1'b1;
    req_offset = 24'h000300;
    req_count = 16'd8;
    pend_clr = 1'b1;
    @(posedge clk);
    #1 begin req_valid = 1'b0; pend_clr = 1'b0; end
    @(negedge clk);
    chk("R10 set wins", 32'(wr_pending), 32'd1);
    chk("R2 single addr", 32'(chunk_addr), 32'h000300);
    chk("R2 single len", 32'(chunk_len), 32'd8);
    chunk_ready = 1'b1;
    @(negedge clk);
    chunk_ready = 1'b0;
    chk("R9 done single", 32'(done), 32'd1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule